// File: doc/BRIEF.md
# Prescaled 16x Oversampling Tick Generator

This block paces one serial channel. It takes the system reference clock and first runs it through a prescaler. A control bit sets the prescaler to pass every cycle (ratio 1) or one cycle in four (ratio 4). The prescaler's enable then drives a 16-bit programmable down-divider. The divider's output is a single-cycle enable at sixteen times the serial bit rate. The transmit shifter and the receive sampler both use it as a clock enable; it is not a derived clock.

The divisor comes from two separately written byte registers, a low byte and a high byte, which are concatenated. The bit rate is reference / prescale / (16 × divisor). For example, a 14.7456 MHz reference with ratio 1 and divisor 1 gives 921600 baud. A divisor of zero parks the generator. A new divisor is taken only when the current count period ends, so a byte write never shortens or splits a pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and while reset is held, `tick16_o` and `presc_tick_o` are 0.
- R2: With `presc_sel_i` = 0 (ratio 1), `presc_tick_o` is 1 on every cycle starting from the first clock edge after reset.
- R3: With `presc_sel_i` = 1 (ratio 4), `presc_tick_o` is 1 on exactly one cycle in every four.
- R4: The divisor is {`div_hi_i`, `div_lo_i`}, with the high byte in bits 15:8. With a steady nonzero divisor N, `tick16_o` is high once every N prescaler ticks, which is every N or 4·N clock cycles depending on the ratio.
- R5: With divisor 1 and ratio 1, `tick16_o` is high on every cycle once running.
- R6: With divisor 0, no `tick16_o` pulse is produced after the period already in progress ends.
- R7: A divisor change takes effect only at the end of the current period. The gap between the two pulses around the change equals the old divisor, and the gaps after it equal the new divisor.
- R8: `tick16_o` is asserted only in the cycle that follows a cycle with `presc_tick_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 1 | Prescale select: 0 gives ratio 1, 1 gives ratio 4 |
| div_lo_i | input | 8 | Divisor low byte |
| div_hi_i | input | 8 | Divisor high byte |
| tick16_o | output | 1 | One-cycle enable at 16x the bit rate |
| presc_tick_o | output | 1 | One-cycle prescaler enable |

## Verification
The embedded properties take for granted that the divisor bytes and the prescale bit change only between clock edges and are otherwise held steady. They do not rely on any particular timing of a divisor write against the count. The stimulus changes all inputs on the falling edge. It holds each setting for many periods, and it also writes a new divisor partway through a period so that the deferred reload is exercised. Every cycle is compared against a behavioural model. Pulse gaps and pulse counts are measured separately over fixed windows.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
    localparam int unsigned DIV_W_DEF   = 16;
    localparam int unsigned PRE_RAT_DEF = 4;

    typedef struct packed {
        logic [7:0] cnt;
        logic       tick;
    } presc_st_t;

    typedef struct packed {
        logic [DIV_W_DEF-1:0] cnt;
        logic                 tick;
    } div_st_t;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baudgen_pkg::*;
#(
    parameter int unsigned RATIO = PRE_RAT_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_i,
    output logic tick_o
);
    localparam logic [7:0] LAST = 8'(RATIO - 1);

    presc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_i) begin
            st_d.tick = (st_q.cnt == LAST);
            st_d.cnt  = (st_q.cnt == LAST) ? 8'd0 : st_q.cnt + 8'd1;
        end else begin
            st_d.tick = 1'b1;
            st_d.cnt  = 8'd0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> tick_o); // R2

    AST_DIV4_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && tick_o) |=> !tick_o); // R3
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baudgen_pkg::*;
#(
    parameter int unsigned DIV_W = DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (en_i) begin
            if (st_q.cnt == DIV_W'(1)) begin
                st_d.tick = 1'b1;
                st_d.cnt  = div_i;
            end else if (st_q.cnt == '0) begin
                st_d.cnt  = div_i;
            end else begin
                st_d.cnt  = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_TICK_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(en_i)); // R8

    AST_PARKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == '0) |=> !tick_o); // R6

    AST_CONTINUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && st_q.cnt == DIV_W'(1) && div_i == DIV_W'(1)) |=> (st_q.cnt == DIV_W'(1))); // R5
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter int unsigned DIV_W     = DIV_W_DEF,
    parameter int unsigned PRE_RATIO = PRE_RAT_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             presc_sel_i,
    input  logic [DIV_W/2-1:0] div_lo_i,
    input  logic [DIV_W/2-1:0] div_hi_i,
    output logic             tick16_o,
    output logic             presc_tick_o
);
    logic [DIV_W-1:0] divisor;
    logic             pre_en;

    assign divisor = {div_hi_i, div_lo_i};

    generate
        if (PRE_RATIO > 1) begin : g_presc
            baud_prescaler #(.RATIO(PRE_RATIO)) u_presc (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .sel_i  (presc_sel_i),
                .tick_o (pre_en)
            );
        end else begin : g_nopresc
            logic byp_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) byp_q <= 1'b0;
                else         byp_q <= 1'b1;
            end
            assign pre_en = byp_q;
        end
    endgenerate

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (pre_en),
        .div_i  (divisor),
        .tick_o (tick16_o)
    );

    assign presc_tick_o = pre_en;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (!tick16_o || !rst_ni)); // R1
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] lo = 8'd0;
    logic [7:0] hi = 8'd0;
    logic       tick16, ptick;

    int vecs = 0;
    int errs = 0;
    int cyc = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    baud_tick_gen u0 (
        .clk_i(clk), .rst_ni(rst_n), .presc_sel_i(sel),
        .div_lo_i(lo), .div_hi_i(hi),
        .tick16_o(tick16), .presc_tick_o(ptick)
    );

    // behavioural reference
    int m_pc = 0, m_cnt = 0;
    bit m_pt = 0, m_tk = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pc = 0; m_cnt = 0; m_pt = 0; m_tk = 0;
        end else begin
            bit npt, ntk;
            int dv;
            dv  = {hi, lo};
            npt = sel ? (m_pc == 3) : 1'b1;
            m_pc = sel ? (m_pc + 1) % 4 : 0;
            ntk = 0;
            if (m_pt) begin
                if (m_cnt == 1) begin ntk = 1; m_cnt = dv; end
                else if (m_cnt == 0) m_cnt = dv;
                else m_cnt = m_cnt - 1;
            end
            m_pt = npt; m_tk = ntk;
        end
    end

    task automatic check(input string r, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        check({tag, " tick16"}, tick16, m_tk);
        check({tag, " presc"}, ptick, m_pt);
    end

    task automatic setup(input bit s, input int dv, input string t);
        @(negedge clk);
        sel = s; lo = dv[7:0]; hi = dv[15:8]; tag = t;
    endtask

    task automatic count_ticks(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.1;
            if (tick16) c++;
        end
    endtask

    task automatic count_presc(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.1;
            if (ptick) c++;
        end
    endtask

    task automatic wait_tick(output int at);
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #0.1;
            if (tick16) begin at = cyc; break; end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin : stim
        int c, t0, t1, t2;
        repeat (4) @(negedge clk);
        check("R1 reset tick16", tick16, 0);
        check("R1 reset presc", ptick, 0);
        @(negedge clk); rst_n = 1'b1;

        setup(0, 5, "R4");
        repeat (20) @(negedge clk);
        count_presc(40, c);  check("R2 presc count", c, 40);
        count_ticks(100, c); check("R4 div5 ratio1", c, 20);

        setup(1, 3, "R3");
        repeat (40) @(negedge clk);
        count_presc(40, c);  check("R3 presc count", c, 10);
        count_ticks(120, c); check("R4 div3 ratio4", c, 10);

        setup(0, 256, "R4");
        repeat (600) @(negedge clk);
        count_ticks(512, c); check("R4 high byte", c, 2);

        setup(0, 1, "R5");
        repeat (600) @(negedge clk);
        count_ticks(50, c);  check("R5 continuous", c, 50);

        setup(0, 0, "R6");
        repeat (10) @(negedge clk);
        count_ticks(300, c); check("R6 stopped", c, 0);

        setup(0, 10, "R7");
        wait_tick(t0);
        repeat (2) @(negedge clk);
        lo = 8'd3;
        wait_tick(t1);
        wait_tick(t2);
        check("R7 old gap", t1 - t0, 10);
        check("R7 new gap", t2 - t1, 3);

        setup(1, 2, "R8");
        repeat (200) @(negedge clk);
        count_ticks(80, c);  check("R8 ratio4 div2", c, 10);

        @(negedge clk); rst_n = 1'b0; tag = "R1";
        @(negedge clk);
        check("R1 in reset tick16", tick16, 0);
        check("R1 in reset presc", ptick, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule